// File: doc/BRIEF.md
# DMA Transfer Address, Count and Fault Status Registers

This block holds the register state that a separate DMA transfer engine works from: a 22-bit word-aligned transfer address, a 14-bit transfer count, an enable flag and a direction flag. The CPU loads these through a simple register port. Each access is a single-cycle write strobe with a register select. A count write carries the enable and direction flags in its two top data bits. The address is loaded in two halves. The value for each half comes from the address lines of the write cycle rather than from the data bus, and address line 14 picks the half.

The block also records faults on DMA accesses. Each cycle, an external permission checker may report a result for the current DMA address. When that result is a fault, the block captures three status words: a general status code, an upper-address word and a lower-address word. If error reporting is enabled, it also raises a one-cycle level-7 (non-maskable) interrupt request. The CPU can read the status words, overwrite the general status word, or reset all three to their idle value.

Top module: `dxr_top`

## Requirements
- R1: After reset, the count is 0, the address is 0, the enable and direction flags are 0, the three status words read 0xFFFF, and the interrupt request is low.
- R2: A write to the count register (select 0) stores data bits 13:0 plus one, modulo 2^14. Writing 0x3FFF therefore leaves a count of 0.
- R3: The same count write sets the direction flag from data bit 14 (1 = DMA reads memory) and the enable flag from data bit 15.
- R4: Reading select 0 returns the stored count in bits 13:0 with bits 15 and 14 both 1.
- R5: An address write (select 1) with bus address line 14 high loads DMA address bits 21:9 from bus address lines 13:1 and keeps DMA address bits 8:0.
- R6: An address write with line 14 low loads DMA address bits 8:1 from bus address lines 8:1 and keeps bits 21:9. DMA address bit 0 is always 0.
- R7: Checker codes are 0 = allowed, 1 = page fault, 2 = user I/O violation, 3 = kernel or write-protect violation. On a fault the general status word (select 2) becomes 0xABFF, 0xBAFF or 0xBBFF for codes 1, 2 and 3. Bit 14 is ORed in when the faulting access is a DMA read, and bit 10 when parity-interrupt-enable is set.
- R8: On a fault, status word 0 (select 3) becomes 0x3C00 ORed with DMA address bits 21:16, and status word 1 (select 4) becomes DMA address bits 15:0.
- R9: A fault pulses the interrupt request high for exactly one cycle, and only when error-enable is set. Error-enable is data bit 15 of a select 5 write. Parity-interrupt-enable is data bit 15 of a select 6 write.
- R10: A checker result of code 0 leaves all status words unchanged and raises no interrupt.
- R11: A select 2 write loads the general status word from the data bus. A select 7 write sets all three status words to 0xFFFF.
- R12: When a fault and a CPU write to the status words (select 2 or 7) occur in the same cycle, the fault values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Single-cycle register write strobe |
| reg_sel | input | 3 | Register select for both write and read |
| wr_data | input | 16 | Write data bus |
| bus_a | input | 14 (bits 14:1) | CPU address lines of the write cycle |
| rd_data | output | 16 | Read data for reg_sel (0xFFFF for write-only selects) |
| chk_valid | input | 1 | Permission-check result present this cycle |
| chk_code | input | 2 | Permission-check result code |
| chk_read | input | 1 | The checked DMA access is a memory read |
| dma_addr | output | 22 | Current DMA byte address |
| dma_count | output | 14 | Current DMA count |
| dma_enable | output | 1 | DMA enable flag |
| dma_read_dir | output | 1 | DMA direction flag |
| nmi_req | output | 1 | Level-7 interrupt request pulse |

## Verification
Every register update lands on the clock edge that samples the strobe or the checker result. Count, address, status and flag values are therefore due one edge after the stimulus. rd_data is a combinational view of the stored state, and the interrupt pulse is high for the single cycle after the faulting edge. The bench applies each stimulus at a falling edge and removes it at the next falling edge, so exactly one rising edge lies between. It reads the results at that second falling edge, and it checks the interrupt again one cycle later to confirm that it has dropped.

// File: rtl/dxr_pkg.sv
package dxr_pkg;

    localparam int STAT_W = 16;

    typedef enum logic [2:0] {
        SEL_COUNT  = 3'd0,
        SEL_ADDR   = 3'd1,
        SEL_GSTAT  = 3'd2,
        SEL_BSR0   = 3'd3,
        SEL_BSR1   = 3'd4,
        SEL_ERREN  = 3'd5,
        SEL_PARIEN = 3'd6,
        SEL_CLEAR  = 3'd7
    } sel_t;

    typedef enum logic [1:0] {
        CHK_OK   = 2'd0,
        CHK_PAGE = 2'd1,
        CHK_USER = 2'd2,
        CHK_PROT = 2'd3
    } chk_t;

    typedef struct packed {
        logic [STAT_W-1:0] gstat;
        logic [STAT_W-1:0] bsr0;
        logic [STAT_W-1:0] bsr1;
    } stat_t;

    localparam logic [STAT_W-1:0] STAT_IDLE  = 16'hFFFF;
    localparam logic [STAT_W-1:0] BSR0_TAG   = 16'h3C00;
    localparam logic [STAT_W-1:0] RD_DIR_BIT = 16'h4000;
    localparam logic [STAT_W-1:0] PIE_BIT    = 16'h0400;

    // General status code for a DMA fault of the given kind.
    function automatic logic [STAT_W-1:0] fault_code(chk_t c, logic rd, logic pie);
        logic [STAT_W-1:0] v;
        case (c)
            CHK_PAGE: v = 16'hABFF;
            CHK_USER: v = 16'hBAFF;
            default:  v = 16'hBBFF;
        endcase
        if (rd)  v = v | RD_DIR_BIT;
        if (pie) v = v | PIE_BIT;
        return v;
    endfunction

endpackage

// File: rtl/dxr_xfer_regs.sv
module dxr_xfer_regs
    import dxr_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int ADDR_W   = 22,
    parameter int LO_W     = 8,
    parameter int HALF_SEL = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  sel_t                wr_sel,
    input  logic [STAT_W-1:0]   wr_data,
    input  logic [HALF_SEL:1]   bus_a,
    output logic [CNT_W-1:0]    cnt,
    output logic                en,
    output logic                dir,
    output logic [ADDR_W-1:0]   addr
);
    localparam int HI_W = ADDR_W - 1 - LO_W;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic cnt_wr, addr_wr;
    assign cnt_wr  = wr_stb && (wr_sel == SEL_COUNT);
    assign addr_wr = wr_stb && (wr_sel == SEL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            en  <= 1'b0;
            dir <= 1'b0;
        end else if (cnt_wr) begin
            cnt <= wr_data[CNT_W-1:0] + ONE;
            dir <= wr_data[CNT_W];
            en  <= wr_data[CNT_W+1];
        end
    end

    logic [ADDR_W-1:1] addr_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (addr_wr) begin
            if (bus_a[HALF_SEL])
                addr_q[ADDR_W-1:LO_W+1] <= bus_a[HI_W:1];
            else
                addr_q[LO_W:1] <= bus_a[LO_W:1];
        end
    end
    assign addr = {addr_q, 1'b0};

    AST_CNT_LOAD_INC: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(wr_data[CNT_W-1:0]) + ONE)) else $error("count load"); // R2
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && bus_a[HALF_SEL]) |=> (addr[LO_W:0] == $past(addr[LO_W:0]))) else $error("hi half"); // R5
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && !bus_a[HALF_SEL]) |=> $stable(addr[ADDR_W-1:LO_W+1])) else $error("lo half"); // R6
endmodule

// File: rtl/dxr_fault_cap.sv
module dxr_fault_cap
    import dxr_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  sel_t                wr_sel,
    input  logic [STAT_W-1:0]   wr_data,
    input  logic                chk_valid,
    input  chk_t                chk_code,
    input  logic                chk_read,
    input  logic [ADDR_W-1:0]   addr,
    output stat_t               st,
    output logic                nmi_req
);
    logic ee_q, pie_q, fault;
    assign fault = chk_valid && (chk_code != CHK_OK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ee_q  <= 1'b0;
            pie_q <= 1'b0;
        end else if (wr_stb) begin
            if (wr_sel == SEL_ERREN)  ee_q  <= wr_data[STAT_W-1];
            if (wr_sel == SEL_PARIEN) pie_q <= wr_data[STAT_W-1];
        end
    end

    // Fault capture takes priority over CPU writes in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{gstat: STAT_IDLE, bsr0: STAT_IDLE, bsr1: STAT_IDLE};
        end else if (fault) begin
            st.gstat <= fault_code(chk_code, chk_read, pie_q);
            st.bsr0  <= BSR0_TAG | STAT_W'(addr[ADDR_W-1:16]);
            st.bsr1  <= addr[15:0];
        end else if (wr_stb && wr_sel == SEL_CLEAR) begin
            st <= '{gstat: STAT_IDLE, bsr0: STAT_IDLE, bsr1: STAT_IDLE};
        end else if (wr_stb && wr_sel == SEL_GSTAT) begin
            st.gstat <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) nmi_req <= 1'b0;
        else     nmi_req <= fault && ee_q;
    end

    AST_NMI_MASKED: assert property (@(posedge clk) disable iff (rst)
        (fault && !ee_q) |=> !nmi_req) else $error("nmi masked"); // R9
    AST_BSR0_TAGGED: assert property (@(posedge clk) disable iff (rst)
        fault |=> (st.bsr0[15:8] == 8'h3C)) else $error("bsr0 tag"); // R8
    AST_OK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_code == CHK_OK && !wr_stb) |=> ($stable(st) && !nmi_req)) else $error("ok result"); // R10
    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (rst)
        (fault && wr_stb && (wr_sel == SEL_CLEAR || wr_sel == SEL_GSTAT)) |=> (st.bsr0 != STAT_IDLE))
        else $error("fault priority"); // R12
endmodule

// File: rtl/dxr_top.sv
module dxr_top
    import dxr_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int ADDR_W   = 22,
    parameter int LO_W     = 8,
    parameter int HALF_SEL = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  logic [2:0]          reg_sel,
    input  logic [15:0]         wr_data,
    input  logic [HALF_SEL:1]   bus_a,
    output logic [15:0]         rd_data,
    input  logic                chk_valid,
    input  logic [1:0]          chk_code,
    input  logic                chk_read,
    output logic [ADDR_W-1:0]   dma_addr,
    output logic [CNT_W-1:0]    dma_count,
    output logic                dma_enable,
    output logic                dma_read_dir,
    output logic                nmi_req
);
    localparam int PAD_W = STAT_W - CNT_W;

    sel_t  sel;
    stat_t st;
    assign sel = sel_t'(reg_sel);

    dxr_xfer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LO_W(LO_W), .HALF_SEL(HALF_SEL)) u_xfer (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_sel(sel), .wr_data(wr_data),
        .bus_a(bus_a), .cnt(dma_count), .en(dma_enable), .dir(dma_read_dir), .addr(dma_addr)
    );

    dxr_fault_cap #(.ADDR_W(ADDR_W)) u_fault (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_sel(sel), .wr_data(wr_data),
        .chk_valid(chk_valid), .chk_code(chk_t'(chk_code)), .chk_read(chk_read),
        .addr(dma_addr), .st(st), .nmi_req(nmi_req)
    );

    always_comb begin
        case (sel)
            SEL_COUNT: rd_data = {{PAD_W{1'b1}}, dma_count};
            SEL_GSTAT: rd_data = st.gstat;
            SEL_BSR0:  rd_data = st.bsr0;
            SEL_BSR1:  rd_data = st.bsr1;
            default:   rd_data = STAT_IDLE;
        endcase
    end

    AST_COUNT_VIEW: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_COUNT) |-> (rd_data[15:14] == 2'b11)) else $error("count view"); // R4
endmodule

// File: tb/sim_dxr_top.sv
module sim_dxr_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_stb;
    logic [2:0]  reg_sel;
    logic [15:0] wr_data;
    logic [14:1] bus_a;
    logic [15:0] rd_data;
    logic        chk_valid;
    logic [1:0]  chk_code;
    logic        chk_read;
    logic [21:0] dma_addr;
    logic [13:0] dma_count;
    logic        dma_enable, dma_read_dir, nmi_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dxr_top u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .reg_sel(reg_sel), .wr_data(wr_data),
        .bus_a(bus_a), .rd_data(rd_data), .chk_valid(chk_valid), .chk_code(chk_code),
        .chk_read(chk_read), .dma_addr(dma_addr), .dma_count(dma_count),
        .dma_enable(dma_enable), .dma_read_dir(dma_read_dir), .nmi_req(nmi_req)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One register write: one rising edge between the two falling edges.
    task automatic wr(logic [2:0] s, logic [15:0] d, logic [23:0] a);
        @(negedge clk);
        wr_stb = 1'b1; reg_sel = s; wr_data = d; bus_a = a[14:1];
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(logic [2:0] s, output logic [15:0] v);
        reg_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic fault(logic [1:0] c, logic r);
        @(negedge clk);
        chk_valid = 1'b1; chk_code = c; chk_read = r;
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1", "count", 32'(dma_count), 32'h0);
        chk("R1", "addr", 32'(dma_addr), 32'h0);
        chk("R1", "en/dir", {30'd0, dma_enable, dma_read_dir}, 32'h0);
        chk("R1", "nmi", 32'(nmi_req), 32'h0);
        rd(3'd2, v); chk("R1", "gstat", 32'(v), 32'hFFFF);
        rd(3'd3, v); chk("R1", "bsr0", 32'(v), 32'hFFFF);
        rd(3'd4, v); chk("R1", "bsr1", 32'(v), 32'hFFFF);
    endtask

    task automatic t_count();
        logic [15:0] v;
        wr(3'd0, 16'h8123, 24'h0);
        chk("R2", "count+1", 32'(dma_count), 32'h124);
        chk("R3", "enable", 32'(dma_enable), 32'h1);
        chk("R3", "dir", 32'(dma_read_dir), 32'h0);
        rd(3'd0, v); chk("R4", "count read", 32'(v), 32'hC124);
        wr(3'd0, 16'h7FFF, 24'h0);
        chk("R2", "count wrap", 32'(dma_count), 32'h0);
        chk("R3", "enable off", 32'(dma_enable), 32'h0);
        chk("R3", "dir read", 32'(dma_read_dir), 32'h1);
        rd(3'd0, v); chk("R4", "count read wrap", 32'(v), 32'hC000);
    endtask

    task automatic t_addr();
        wr(3'd1, 16'h0, 24'h004000 | (24'h1ABC << 1));
        chk("R5", "hi half", 32'(dma_addr), 32'h357800);
        wr(3'd1, 16'hFFFF, 24'h00014B);
        chk("R6", "lo half, bit0 zero", 32'(dma_addr), 32'h35794A);
        wr(3'd1, 16'h0, 24'h004000 | (24'h0001 << 1));
        chk("R5", "hi keeps lo", 32'(dma_addr), 32'h00034A);
        chk("R3", "data bus ignored by addr", 32'(dma_count), 32'h0);
    endtask

    task automatic t_fault_page_read();
        logic [15:0] v;
        wr(3'd1, 16'h0, 24'h004000 | (24'h1F00 << 1));
        wr(3'd5, 16'h8000, 24'h0);
        wr(3'd6, 16'h7FFF, 24'h0);
        fault(2'd1, 1'b1);
        chk("R9", "nmi pulse", 32'(nmi_req), 32'h1);
        rd(3'd2, v); chk("R7", "page read code", 32'(v), 32'hEBFF);
        rd(3'd3, v); chk("R8", "bsr0", 32'(v), 32'h3C3E);
        rd(3'd4, v); chk("R8", "bsr1", 32'(v), 32'h014A);
        @(negedge clk);
        chk("R9", "nmi one cycle", 32'(nmi_req), 32'h0);
    endtask

    task automatic t_fault_user_pie();
        logic [15:0] v;
        wr(3'd6, 16'h8000, 24'h0);
        fault(2'd2, 1'b0);
        chk("R9", "nmi user", 32'(nmi_req), 32'h1);
        rd(3'd2, v); chk("R7", "user write pie code", 32'(v), 32'hBEFF);
    endtask

    task automatic t_fault_prot_noee();
        logic [15:0] v;
        wr(3'd5, 16'h7FFF, 24'h0);
        wr(3'd6, 16'h0000, 24'h0);
        wr(3'd1, 16'h0, 24'h000010);
        fault(2'd3, 1'b1);
        chk("R9", "nmi masked", 32'(nmi_req), 32'h0);
        rd(3'd2, v); chk("R7", "prot read code", 32'(v), 32'hFBFF);
        rd(3'd3, v); chk("R8", "bsr0 prot", 32'(v), 32'h3C3E);
        rd(3'd4, v); chk("R8", "bsr1 prot", 32'(v), 32'h0010);
    endtask

    task automatic t_cpu_status();
        logic [15:0] v;
        wr(3'd2, 16'h1234, 24'h0);
        rd(3'd2, v); chk("R11", "gstat load", 32'(v), 32'h1234);
        wr(3'd7, 16'h0, 24'h0);
        rd(3'd2, v); chk("R11", "clear gstat", 32'(v), 32'hFFFF);
        rd(3'd3, v); chk("R11", "clear bsr0", 32'(v), 32'hFFFF);
        rd(3'd4, v); chk("R11", "clear bsr1", 32'(v), 32'hFFFF);
        wr(3'd5, 16'h8000, 24'h0);
        fault(2'd0, 1'b1);
        chk("R10", "ok no nmi", 32'(nmi_req), 32'h0);
        rd(3'd2, v); chk("R10", "ok gstat kept", 32'(v), 32'hFFFF);
        rd(3'd3, v); chk("R10", "ok bsr0 kept", 32'(v), 32'hFFFF);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        @(negedge clk);
        wr_stb = 1'b1; reg_sel = 3'd7; wr_data = 16'h0; bus_a = '0;
        chk_valid = 1'b1; chk_code = 2'd1; chk_read = 1'b0;
        @(negedge clk);
        wr_stb = 1'b0; chk_valid = 1'b0;
        rd(3'd2, v); chk("R12", "fault beats clear", 32'(v), 32'hABFF);
        rd(3'd3, v); chk("R12", "bsr0 kept", 32'(v), 32'h3C3E);
        @(negedge clk);
        wr_stb = 1'b1; reg_sel = 3'd2; wr_data = 16'h0055;
        chk_valid = 1'b1; chk_code = 2'd2; chk_read = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; chk_valid = 1'b0;
        rd(3'd2, v); chk("R12", "fault beats gstat write", 32'(v), 32'hFAFF);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_stb = 1'b0; reg_sel = '0; wr_data = '0; bus_a = '0;
        chk_valid = 1'b0; chk_code = '0; chk_read = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_addr();
        t_fault_page_read();
        t_fault_user_pie();
        t_fault_prot_noee();
        t_cpu_status();
        t_collide();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule